// File: doc/BRIEF.md
# Latched-Address Fuse ROM

This block is a synthesizable behavioural model of a one-time-programmable read-only store of 2048 bytes. An access starts when the active-low chip select `ce_n` is first sampled low on the system clock. The address present at that clock edge is captured and held for the rest of the access. Address changes while the select stays low have no effect on the word being read.

The byte is driven onto `data_out` only after a fixed number of clocks has passed since the select fell and since the active-low output gate `oe_n` fell. `data_valid` stands in for three-state drive: while it is low, `data_out` is forced to zero. Storage is arranged as a square of 128 lines of 128 bits. The upper seven address bits choose a line and the lower four choose one byte within it.

A write port with an active-low unlock (`pe_n`) can only add ones. A request that would turn any stored one back into zero is refused and flagged. The minimum select-high time and the minimum spacing between accesses are checked in clock cycles, and a violation is reported on `timing_err`.

Top module: `otp_latched_rom`

## Requirements
- R1: After reset, and for as long as `rst_n` is low, `data_valid`, `data_out`, `prog_err` and `timing_err` are all zero.
- R2: A word that was never programmed reads as 8'h00.
- R3: The word read is the one at the address sampled on the first clock edge where `ce_n` is low after being high. Changes to `addr` while `ce_n` stays low do not change `data_out`.
- R4: Address bits [10:4] select one of 128 storage lines, and bits [3:0] select one of 16 byte slots in that line. Every one of the 2048 addresses holds its own independent byte.
- R5: `data_valid` is high after the third consecutive edge with `ce_n` sampled low, provided that edge also has at least one consecutive edge with `oe_n` sampled low (the later of the two conditions decides). Whenever `data_valid` is low, `data_out` is 8'h00.
- R6: One edge with `oe_n` or `ce_n` sampled high makes `data_valid` low after that edge. It rises again one edge after `oe_n` returns low if the select has stayed low.
- R7: An edge with `pe_n` low and `prog_req` high, where `prog_data` keeps every bit already set in the word at `addr`, stores `prog_data` there. The new value is readable from the next cycle.
- R8: A program request whose `prog_data` would clear a stored one leaves the word unchanged and raises `prog_err` for exactly the cycle after that edge. No programming step ever turns a one into a zero.
- R9: With `pe_n` high, `prog_req` is ignored: the word keeps its value and `prog_err` stays low.
- R10: A select fall that follows fewer than `MIN_EHI_CYC` consecutive high samples of `ce_n` raises `timing_err` for one cycle after that fall.
- R11: A select fall that comes fewer than `MIN_CYC_CYC` edges after the previous fall raises `timing_err` for one cycle. Spacing of exactly `MIN_CYC_CYC` edges is legal.
- R12: Stored words survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip select; its fall starts an access |
| oe_n | input | 1 | Active-low output gate |
| pe_n | input | 1 | Active-low programming unlock |
| addr | input | 11 | Word address (line in [10:4], byte slot in [3:0]) |
| prog_req | input | 1 | Program request, acted on when unlocked |
| prog_data | input | 8 | New word value; may only add ones |
| data_out | output | 8 | Read byte, zero when not driven |
| data_valid | output | 1 | High while the outputs are driven |
| prog_err | output | 1 | One-cycle pulse: program request refused |
| timing_err | output | 1 | One-cycle pulse: select pulse or access spacing too short |

## Verification
The bench moves the address after the select has already fallen. A design that latches on level instead of on the edge would then return the byte from the new address. It holds `oe_n` high past the select delay to show that the later of the two delays decides when `data_valid` rises; a design that used only the select delay would drive early. It programs bytes that share a line or a slot, and a wrong line/slot split would alias them. It also sends a refused write, an unlocked-only write and a reset, which expose a design that clears fuses, writes while locked, or wipes storage on reset. Select pulses are placed exactly at and one edge below each minimum, so an off-by-one in either timing counter shows up as a missing or spurious `timing_err`.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

   // Bits needed to hold the values 0..maxv
   function automatic int cnt_w(input int maxv);
      return (maxv < 1) ? 1 : $clog2(maxv + 1);
   endfunction

   // What the programming port does on a given edge
   typedef enum logic [1:0] {
      PG_IDLE   = 2'd0,
      PG_WRITE  = 2'd1,
      PG_REJECT = 2'd2
   } pg_op_e;

endpackage

// File: rtl/otp_sat_cnt.sv
module otp_sat_cnt
   import otp_rom_pkg::*;
#(
   parameter int MAX       = 3,
   parameter bit IDLE_FULL = 1'b0,
   localparam int W        = cnt_w(MAX)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         restart,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] TOP = W'(MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= IDLE_FULL ? TOP : W'(0);
      end else if (clr) begin
         cnt <= W'(0);
      end else if (restart) begin
         cnt <= W'(1);
      end else if (cnt < TOP) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/otp_access_timer.sv
module otp_access_timer
   import otp_rom_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int E2D_CYC     = 3,
   parameter int G2D_CYC     = 1,
   parameter int MIN_EHI_CYC = 1,
   parameter int MIN_CYC_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] addr_lat,
   output logic              drive,
   output logic              timing_err
);

   localparam int EW = cnt_w(E2D_CYC);
   localparam int GW = cnt_w(G2D_CYC);
   localparam int CW = cnt_w(MIN_CYC_CYC);

   logic          ce_q;
   logic          fall;
   logic          short_high;
   logic          short_cycle;
   logic [EW-1:0] e_cnt;
   logic [GW-1:0] g_cnt;
   logic [CW-1:0] cyc_cnt;

   assign fall = ce_q & ~ce_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q       <= 1'b1;
         addr_lat   <= '0;
         timing_err <= 1'b0;
      end else begin
         ce_q       <= ce_n;
         timing_err <= fall & (short_high | short_cycle);
         if (fall) begin
            addr_lat <= addr;
         end
      end
   end

   // Low-time counters for the two enables
   otp_sat_cnt #(.MAX(E2D_CYC), .IDLE_FULL(1'b0)) u_e_age (
      .clk(clk), .rst_n(rst_n), .clr(ce_n), .restart(1'b0), .cnt(e_cnt)
   );

   otp_sat_cnt #(.MAX(G2D_CYC), .IDLE_FULL(1'b0)) u_g_age (
      .clk(clk), .rst_n(rst_n), .clr(oe_n), .restart(1'b0), .cnt(g_cnt)
   );

   // Edges since the last select fall; idles full so the first access is legal
   otp_sat_cnt #(.MAX(MIN_CYC_CYC), .IDLE_FULL(1'b1)) u_cyc_age (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .restart(fall), .cnt(cyc_cnt)
   );

   assign short_cycle = cyc_cnt < CW'(MIN_CYC_CYC);

   // A one-cycle minimum high time is always met: no counter needed then
   generate
      if (MIN_EHI_CYC > 1) begin : g_hi_check
         localparam int HW = cnt_w(MIN_EHI_CYC);
         logic [HW-1:0] hi_cnt;
         otp_sat_cnt #(.MAX(MIN_EHI_CYC), .IDLE_FULL(1'b1)) u_hi_age (
            .clk(clk), .rst_n(rst_n), .clr(~ce_n), .restart(1'b0), .cnt(hi_cnt)
         );
         assign short_high = hi_cnt < HW'(MIN_EHI_CYC);
      end else begin : g_hi_free
         assign short_high = 1'b0;
      end
   endgenerate

   assign drive = (e_cnt >= EW'(E2D_CYC)) && (g_cnt >= GW'(G2D_CYC));

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
   import otp_rom_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter int COL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word,
   input  logic              pg_en,
   input  logic [ADDR_W-1:0] pg_addr,
   input  logic [DATA_W-1:0] pg_data,
   output logic              pg_err
);

   localparam int ROW_W  = ADDR_W - COL_W;
   localparam int ROWS   = 2 ** ROW_W;
   localparam int COLS   = 2 ** COL_W;
   localparam int LINE_W = COLS * DATA_W;

   // Fuses start unblown; no reset so contents outlive rst_n
   logic [LINE_W-1:0] lines [ROWS] = '{default: '0};

   logic [ROW_W-1:0]  rd_row;
   logic [COL_W-1:0]  rd_col;
   logic [LINE_W-1:0] rd_line;
   logic [ROW_W-1:0]  pg_row;
   logic [COL_W-1:0]  pg_col;
   logic [LINE_W-1:0] pg_line;
   logic [LINE_W-1:0] pg_next;
   logic [DATA_W-1:0] pg_cur;
   pg_op_e            pg_op;

   assign rd_row  = rd_addr[ADDR_W-1:COL_W];
   assign rd_col  = rd_addr[COL_W-1:0];
   assign rd_line = lines[rd_row];
   assign rd_word = rd_line[rd_col*DATA_W +: DATA_W];

   assign pg_row  = pg_addr[ADDR_W-1:COL_W];
   assign pg_col  = pg_addr[COL_W-1:0];
   assign pg_line = lines[pg_row];
   assign pg_cur  = pg_line[pg_col*DATA_W +: DATA_W];

   always_comb begin
      if (!pg_en) begin
         pg_op = PG_IDLE;
      end else if (|(pg_cur & ~pg_data)) begin
         pg_op = PG_REJECT;
      end else begin
         pg_op = PG_WRITE;
      end
   end

   always_comb begin
      pg_next = pg_line;
      pg_next[pg_col*DATA_W +: DATA_W] = pg_data;
   end

   always_ff @(posedge clk) begin
      if (pg_op == PG_WRITE) begin
         lines[pg_row] <= pg_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_err <= 1'b0;
      end else begin
         pg_err <= (pg_op == PG_REJECT);
      end
   end

endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom
   import otp_rom_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 8,
   parameter int COL_W       = 4,
   parameter int E2D_CYC     = 3,
   parameter int G2D_CYC     = 1,
   parameter int MIN_EHI_CYC = 1,
   parameter int MIN_CYC_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              pe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              prog_req,
   input  logic [DATA_W-1:0] prog_data,
   output logic [DATA_W-1:0] data_out,
   output logic              data_valid,
   output logic              prog_err,
   output logic              timing_err
);

   // Elaboration-time parameter checks
   generate
      if (COL_W < 1 || ADDR_W <= COL_W) begin : g_bad_split
         $error("otp_latched_rom: address split needs 1 <= COL_W < ADDR_W");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("otp_latched_rom: DATA_W must be at least 1");
      end
      if (E2D_CYC < 1 || G2D_CYC < 1 || MIN_CYC_CYC < 1 || MIN_EHI_CYC < 1) begin : g_bad_timing
         $error("otp_latched_rom: cycle counts must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_lat;
   logic              drive;
   logic [DATA_W-1:0] rd_word;

   otp_access_timer #(
      .ADDR_W(ADDR_W), .E2D_CYC(E2D_CYC), .G2D_CYC(G2D_CYC),
      .MIN_EHI_CYC(MIN_EHI_CYC), .MIN_CYC_CYC(MIN_CYC_CYC)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
      .addr_lat(addr_lat), .drive(drive), .timing_err(timing_err)
   );

   otp_fuse_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .rd_addr(addr_lat), .rd_word(rd_word),
      .pg_en(~pe_n & prog_req), .pg_addr(addr), .pg_data(prog_data),
      .pg_err(prog_err)
   );

   assign data_valid = drive;
   assign data_out   = drive ? rd_word : '0;

endmodule

// File: rtl/otp_latched_rom_chk.sv
module otp_latched_rom_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              pe_n,
   input logic              prog_req,
   input logic [DATA_W-1:0] data_out,
   input logic              data_valid,
   input logic              prog_err,
   input logic              timing_err
);

   // R5: undriven bus reads as zero
   a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |-> (data_out == '0));

   // R6: a high sample of either enable stops the drive after that edge
   a_r6_enable_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(oe_n) || $past(ce_n)) |-> !data_valid);

   // R3: a held access keeps its word unless a program step intervened
   a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && $past(data_valid) && !$past(prog_req && !pe_n)) |-> $stable(data_out));

   // R8: a driven word never loses a one
   a_r8_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && $past(data_valid)) |-> (($past(data_out) & ~data_out) == '0));

   // R8: a refusal only follows an unlocked request
   a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      prog_err |-> $past(prog_req && !pe_n));

   // R9: locked port never reports
   a_r9_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pe_n) |-> !prog_err);

   // R10 and R11: timing flag only after a select fall
   a_r11_terr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      timing_err |-> ($past(!ce_n) && $past(ce_n, 2)));

endmodule

bind otp_latched_rom otp_latched_rom_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pe_n(pe_n),
   .prog_req(prog_req), .data_out(data_out), .data_valid(data_valid),
   .prog_err(prog_err), .timing_err(timing_err)
);

// File: tb/otp_latched_rom_tb.sv
module otp_latched_rom_tb;

   localparam int E2D = 3;
   localparam int G2D = 1;
   localparam int EHI = 2;
   localparam int CYC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        pe_n = 1'b1;
   logic [10:0] addr = '0;
   logic        prog_req = 1'b0;
   logic [7:0]  prog_data = '0;
   logic [7:0]  data_out;
   logic        data_valid;
   logic        prog_err;
   logic        timing_err;

   always #5 clk = ~clk;

   otp_latched_rom #(.MIN_EHI_CYC(EHI)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pe_n(pe_n),
      .addr(addr), .prog_req(prog_req), .prog_data(prog_data),
      .data_out(data_out), .data_valid(data_valid),
      .prog_err(prog_err), .timing_err(timing_err)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit model_on = 1'b0;
   bit ended = 1'b0;

   // Behavioural reference
   logic [7:0] mmem [2048];
   int m_lat, m_e, m_g, m_hi, m_cyc;
   bit m_ceq, m_perr, m_terr;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin : ref_model
      bit fall;
      if (!rst_n) begin
         m_lat = 0; m_e = 0; m_g = 0; m_hi = EHI; m_cyc = CYC;
         m_ceq = 1'b1; m_perr = 1'b0; m_terr = 1'b0;
      end else begin
         fall   = m_ceq && !ce_n;
         m_terr = fall && (m_hi < EHI || m_cyc < CYC);
         if (fall) m_lat = int'(addr);
         m_cyc  = fall ? 1 : ((m_cyc < CYC) ? m_cyc + 1 : m_cyc);
         m_hi   = ce_n ? ((m_hi < EHI) ? m_hi + 1 : m_hi) : 0;
         m_e    = ce_n ? 0 : ((m_e < E2D) ? m_e + 1 : m_e);
         m_g    = oe_n ? 0 : ((m_g < G2D) ? m_g + 1 : m_g);
         m_perr = 1'b0;
         if (!pe_n && prog_req) begin
            if ((mmem[addr] & ~prog_data) != 8'h00) m_perr = 1'b1;
            else mmem[addr] = prog_data;
         end
         m_ceq = ce_n;
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         bit ev;
         ev = (m_e >= E2D) && (m_g >= G2D);
         chk("R5 valid vs model", int'(data_valid), int'(ev));
         chk("R3 data vs model", int'(data_out), ev ? int'(mmem[m_lat]) : 0);
         chk("R8 prog_err vs model", int'(prog_err), int'(m_perr));
         chk("R10 timing_err vs model", int'(timing_err), int'(m_terr));
      end
   end

   task automatic do_read(input logic [10:0] a, output logic [7:0] d);
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; addr = a;
      repeat (E2D) @(negedge clk);
      d = data_out;
      chk("R5 valid after select delay", int'(data_valid), 1);
      ce_n = 1'b1; oe_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_prog(input logic [10:0] a, input logic [7:0] v,
                          input bit unlock, output bit err);
      @(negedge clk);
      pe_n = !unlock; prog_req = 1'b1; addr = a; prog_data = v;
      @(negedge clk);
      err = prog_err;
      pe_n = 1'b1; prog_req = 1'b0;
   endtask

   initial begin
      logic [7:0] d;
      bit e;
      for (int i = 0; i < 2048; i++) mmem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_on = 1'b1;
      chk("R1 valid after reset", int'(data_valid), 0);
      chk("R1 data after reset", int'(data_out), 0);
      chk("R1 errors after reset", int'({prog_err, timing_err}), 0);

      do_read(11'h123, d);
      chk("R2 blank word", int'(d), 8'h00);

      do_prog(11'h123, 8'h5A, 1'b1, e);
      chk("R7 legal program no error", int'(e), 0);
      do_read(11'h123, d);
      chk("R7 programmed word", int'(d), 8'h5A);

      do_prog(11'h123, 8'h0F, 1'b1, e);
      chk("R8 clearing request flagged", int'(e), 1);
      do_read(11'h123, d);
      chk("R8 word unchanged", int'(d), 8'h5A);

      do_prog(11'h124, 8'hFF, 1'b0, e);
      chk("R9 locked request no error", int'(e), 0);
      do_read(11'h124, d);
      chk("R9 locked word unchanged", int'(d), 8'h00);

      do_prog(11'h7F0, 8'h81, 1'b1, e);
      do_prog(11'h00F, 8'h3C, 1'b1, e);
      do_read(11'h7F0, d);
      chk("R4 top line slot 0", int'(d), 8'h81);
      do_read(11'h00F, d);
      chk("R4 line 0 slot 15", int'(d), 8'h3C);
      do_read(11'h0F0, d);
      chk("R4 other line same slot", int'(d), 8'h00);
      do_read(11'h7F3, d);
      chk("R4 same line other slot", int'(d), 8'h00);

      // Delay ordering, address hold and release
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b1; addr = 11'h123;
      @(negedge clk);
      chk("R5 not valid after 1 edge", int'(data_valid), 0);
      addr = 11'h7F0;
      @(negedge clk);
      chk("R5 not valid after 2 edges", int'(data_valid), 0);
      @(negedge clk);
      chk("R5 gate still closed", int'(data_valid), 0);
      oe_n = 1'b0;
      @(negedge clk);
      chk("R5 valid one edge after gate", int'(data_valid), 1);
      chk("R3 latched word kept", int'(data_out), 8'h5A);
      oe_n = 1'b1;
      @(negedge clk);
      chk("R6 gate release", int'(data_valid), 0);
      chk("R6 bus zero when released", int'(data_out), 0);
      oe_n = 1'b0;
      @(negedge clk);
      chk("R6 gate reopened", int'(data_valid), 1);
      ce_n = 1'b1;
      @(negedge clk);
      chk("R6 select release", int'(data_valid), 0);
      oe_n = 1'b1;
      repeat (4) @(negedge clk);

      // Minimum high time
      ce_n = 1'b0;
      repeat (5) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      @(negedge clk);
      chk("R10 short high flagged", int'(timing_err), 1);
      @(negedge clk);
      chk("R10 flag is one pulse", int'(timing_err), 0);
      ce_n = 1'b1;
      repeat (2) @(negedge clk);
      ce_n = 1'b0;
      @(negedge clk);
      chk("R11 exact minimum cycle legal", int'(timing_err), 0);
      ce_n = 1'b1;
      repeat (2) @(negedge clk);
      ce_n = 1'b0;
      @(negedge clk);
      chk("R11 short cycle flagged", int'(timing_err), 1);
      ce_n = 1'b1;
      repeat (4) @(negedge clk);

      // Contents across reset
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 valid low in reset", int'(data_valid), 0);
      chk("R1 timing flag low in reset", int'(timing_err), 0);
      rst_n = 1'b1;
      do_read(11'h123, d);
      chk("R12 word kept over reset", int'(d), 8'h5A);
      do_read(11'h7F0, d);
      chk("R12 second word kept", int'(d), 8'h81);

      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 run did not finish actual=%0d expected=%0d", 20000, 0);
         report();
      end
   end

endmodule